// File: doc/BRIEF.md
# I2C Stuck-Bus Recovery Sequencer

This block frees an I2C bus on which a target device is holding SDA low, typically because a transfer was cut off part-way and the target still wants to shift out bits. On a single-cycle software trigger it first asks the high-level transaction engine to halt. Once the engine reports it is idle, the block toggles SCL through an override output while leaving SDA released, so that the target can finish its byte and let go of the data line.

Each clock cycle on the bus has two equal phases. In the first, the override is released and SCL floats high. In the second, the override pulls SCL low. Both phases last a parameterised number of system clocks, which defaults to 5 µs at 100 MHz. At the end of every released phase the synchronised SDA and SCL levels are checked. If either line reads high, the bus is taken as freed: the sequence stops at once and reports success. If the line is still held after the last allowed low phase (nine by default, covering eight data bits plus one), the sequence stops and reports failure. Generating a STOP condition and resetting the controller are left to other logic.

The control pins are plain levels and pulses. There is no streamed data, so no valid/ready handshake applies.

Top module: `i2c_unstick`

## Requirements
- R1: After reset, `scl_force_low`, `engine_halt`, `done` and `failed` are all 0.
- R2: A `start` pulse while idle raises `engine_halt` and clears `done` and `failed`. No SCL low phase is driven while `eng_idle` stays 0.
- R3: Once `eng_idle` is 1, the block alternates a released phase (`scl_force_low`=0) and a forced phase (`scl_force_low`=1). Each phase lasts exactly `PHASE_CYCLES` clocks, and every run starts with a released phase.
- R4: At the end of each released phase, the block samples SDA and SCL after `SYNC_STAGES` synchroniser flops. If either line reads 1, no further low phase is driven and `done` goes to 1.
- R5: At most `MAX_PULSES` (default 9) low phases are driven per run. If both lines read 0 at every check, `failed` goes to 1 when the last low phase ends.
- R6: When a run ends, `scl_force_low` and `engine_halt` return to 0. `done` and `failed` are never 1 together and hold their value until the next accepted `start`.
- R7: A `start` pulse while a run is in progress is ignored: the number of low phases and the outcome are the same as without it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Single-cycle recovery trigger |
| eng_idle | input | 1 | High-level transaction engine reports it is halted |
| sda_in | input | 1 | Live SDA level (asynchronous) |
| scl_in | input | 1 | Live SCL level (asynchronous) |
| scl_force_low | output | 1 | SCL override: 1 pulls SCL low |
| engine_halt | output | 1 | Request to disable the transaction engine during recovery |
| done | output | 1 | Bus released before the pulse limit |
| failed | output | 1 | Pulse limit reached with the bus still held |

## Verification
The bench uses a target model that releases SDA after a chosen number of low phases. Runs with zero, middle and eight releases separate the early-stop path from the pulse-count limit, and nine or more releases separate the failure path from a late success. A mode in which SCL reads high on release checks that either line alone ends the run. Runs that hold `eng_idle` low show that the block waits for the engine. Runs with a trigger injected mid-sequence show that a second trigger cannot restart the count.

// File: rtl/i2c_unstick_pkg.sv
package i2c_unstick_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HALT = 2'd1,
    ST_HIGH = 2'd2,
    ST_LOW  = 2'd3
  } seq_state_t;
endpackage

// File: rtl/i2c_unstick_sync.sv
module i2c_unstick_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage_q [STAGES];

  // Idle bus lines are high, so the chain resets to ones.
  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) stage_q[s] <= '1;
          else        stage_q[s] <= d;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) stage_q[s] <= '1;
          else        stage_q[s] <= stage_q[s-1];
      end
    end
  endgenerate

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/i2c_unstick_timer.sv
module i2c_unstick_timer #(
  parameter int CYCLES = 500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic expire
);
  localparam int W = (CYCLES > 1) ? $clog2(CYCLES) : 1;

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load)           cnt_q <= W'(CYCLES - 1);
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign expire = (cnt_q == '0);

  // R3: the phase counter steps down by one per clock until reloaded
  assert_phase_countdown_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/i2c_unstick.sv
module i2c_unstick
  import i2c_unstick_pkg::*;
#(
  parameter int PHASE_CYCLES = 500,
  parameter int MAX_PULSES   = 9,
  parameter int SYNC_STAGES  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic eng_idle,
  input  logic sda_in,
  input  logic scl_in,
  output logic scl_force_low,
  output logic engine_halt,
  output logic done,
  output logic failed
);
  localparam int CW = $clog2(MAX_PULSES + 1);
  localparam logic [CW-1:0] LAST_PULSE = CW'(MAX_PULSES);

  seq_state_t    state_q;
  logic [CW-1:0] pulse_q;
  logic          done_q, failed_q;
  logic [1:0]    lines_s;
  logic          sda_s, scl_s, lines_low;
  logic          phase_load, phase_end;

  i2c_unstick_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({sda_in, scl_in}), .q(lines_s)
  );
  assign sda_s     = lines_s[1];
  assign scl_s     = lines_s[0];
  assign lines_low = !sda_s && !scl_s;

  always_comb begin
    phase_load = 1'b0;
    unique case (state_q)
      ST_HALT: phase_load = eng_idle;
      ST_HIGH: phase_load = phase_end && lines_low;
      ST_LOW:  phase_load = phase_end && (pulse_q != LAST_PULSE);
      default: phase_load = 1'b0;
    endcase
  end

  i2c_unstick_timer #(.CYCLES(PHASE_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(phase_load), .expire(phase_end)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      pulse_q  <= '0;
      done_q   <= 1'b0;
      failed_q <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start) begin
          state_q  <= ST_HALT;
          pulse_q  <= '0;
          done_q   <= 1'b0;
          failed_q <= 1'b0;
        end
        ST_HALT: if (eng_idle) state_q <= ST_HIGH;
        ST_HIGH: if (phase_end) begin
          if (lines_low) begin
            state_q <= ST_LOW;
            pulse_q <= pulse_q + 1'b1;
          end else begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
          end
        end
        ST_LOW: if (phase_end) begin
          if (pulse_q == LAST_PULSE) begin
            state_q  <= ST_IDLE;
            failed_q <= 1'b1;
          end else begin
            state_q <= ST_HIGH;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign scl_force_low = (state_q == ST_LOW);
  assign engine_halt   = (state_q != ST_IDLE);
  assign done          = done_q;
  assign failed        = failed_q;

  // R2: no clocking while the engine has not yet reported idle
  assert_wait_engine_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_HALT && !eng_idle) |=> (state_q == ST_HALT && !scl_force_low));

  // R4: a low phase only starts when both lines were sampled low
  assert_low_needs_stuck_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scl_force_low) |-> $past(lines_low));

  // R5: the pulse count never passes the limit
  assert_pulse_cap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_q <= LAST_PULSE);

  // R6: the two outcomes are exclusive
  assert_outcome_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_q && failed_q));

  // R7: a trigger during a run never clears the pulse count
  assert_busy_trigger_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_IDLE && start) |=> (pulse_q >= $past(pulse_q)));
endmodule

// File: tb/i2c_unstick_bench.sv
`timescale 1ns/1ps
module i2c_unstick_bench;
  localparam int P   = 20;
  localparam int MAXP = 9;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic eng_idle = 1'b0;
  logic sda_in, scl_in;
  logic scl_force_low, engine_halt, done, failed;

  int errors = 0;
  int checks = 0;
  int low_total = 0;
  int low_base = 0;
  int release_after = 0;
  bit scl_mode = 1'b0;
  int width_err = 0;
  int run_len = 0;
  logic prev_f = 1'b0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  i2c_unstick #(.PHASE_CYCLES(P), .MAX_PULSES(MAXP), .SYNC_STAGES(2)) u_i2c_unstick (
    .clk(clk), .rst_n(rst_n), .start(start), .eng_idle(eng_idle),
    .sda_in(sda_in), .scl_in(scl_in), .scl_force_low(scl_force_low),
    .engine_halt(engine_halt), .done(done), .failed(failed)
  );

  // Target model: holds SDA low until it has seen release_after low phases.
  assign sda_in = ((low_total - low_base) >= release_after);
  assign scl_in = scl_mode ? !scl_force_low : 1'b0;

  // Monitor at the falling edge: count low phases and measure their widths.
  always @(negedge clk) begin
    if (scl_force_low && !prev_f) low_total <= low_total + 1;
    if (scl_force_low) run_len <= run_len + 1;
    else begin
      if (prev_f && run_len != P) width_err <= width_err + 1;
      run_len <= 0;
    end
    prev_f <= scl_force_low;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int exp_pulses(input int rel, input bit sclm);
    if (sclm) return 0;
    return (rel < MAXP) ? rel : MAXP;
  endfunction

  function automatic bit exp_fail(input int rel, input bit sclm);
    return !sclm && (rel >= MAXP);
  endfunction

  task automatic run(input int rel, input bit sclm, input int hold, input bit inject);
    int g;
    bit injected;
    int ep;
    bit ef;
    g = 0;
    injected = 1'b0;
    ep = exp_pulses(rel, sclm);
    ef = exp_fail(rel, sclm);
    scl_mode = sclm;
    release_after = rel;
    low_base = low_total;
    width_err = 0;
    eng_idle = 1'b0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(engine_halt == 1'b1, "R2", "engine_halt after trigger", engine_halt, 1);
    check(done == 1'b0 && failed == 1'b0, "R2", "outcome cleared", {done, failed}, 0);
    if (hold > 0) begin
      repeat (hold) @(negedge clk);
      check(low_total - low_base == 0 && !scl_force_low, "R2", "no pulse while engine busy",
            low_total - low_base, 0);
    end
    eng_idle = 1'b1;
    while (!(done || failed) && g < 5000) begin
      @(negedge clk);
      g++;
      if (inject && !injected && (low_total - low_base) == 2) begin
        start = 1'b1;
        injected = 1'b1;
      end else start = 1'b0;
    end
    start = 1'b0;
    check(g < 5000, "R4", "run completes", g, 0);
    check(low_total - low_base == ep, inject ? "R7" : (ef ? "R5" : "R4"), "low phase count",
          low_total - low_base, ep);
    check(done == !ef, ef ? "R5" : "R4", "done", done, !ef);
    check(failed == ef, "R5", "failed", failed, ef);
    check(width_err == 0, "R3", "phase width errors", width_err, 0);
    check(!scl_force_low && !engine_halt, "R6", "overrides released",
          {scl_force_low, engine_halt}, 0);
    repeat (3) @(negedge clk);
    check(done == !ef && failed == ef, "R6", "outcome held", {done, failed}, {!ef, ef});
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    check(!scl_force_low && !engine_halt && !done && !failed, "R1", "reset outputs",
          {scl_force_low, engine_halt, done, failed}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!scl_force_low && !engine_halt && !done && !failed, "R1", "idle after reset",
          {scl_force_low, engine_halt, done, failed}, 0);
    // Directed corners
    run(0, 1'b0, 0, 1'b0);   // R4: bus already free
    run(1, 1'b0, 4, 1'b0);   // R4: one pulse, engine slow (R2)
    run(8, 1'b0, 0, 1'b0);   // R4: last chance before the limit
    run(9, 1'b0, 2, 1'b0);   // R5: never released in time
    run(20, 1'b0, 0, 1'b1);  // R5/R7: failure with trigger injected
    run(5, 1'b0, 0, 1'b1);   // R7: trigger mid-run
    run(3, 1'b1, 1, 1'b0);   // R4: SCL alone reads high
    // Constrained random
    for (int i = 0; i < 12; i++) begin
      run(int'($urandom_range(0, 11)), ($urandom_range(0, 7) == 0),
          int'($urandom_range(0, 5)), ($urandom_range(0, 3) == 0));
    end
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(150000 * 10);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule